// File: doc/BRIEF.md
# ATM Cell Delineation Unit

This block recovers ATM cell boundaries from a received payload byte stream. The stream can carry up to four tributaries that are byte-interleaved in any order. Every input byte carries a tributary tag. For each tributary the block keeps its own byte history, its own position inside the cell, and its own state. The state moves between searching, confirming and locked. The boundaries of one tributary are never assumed to line up with those of another.

The block finds a boundary by checking the header error code. The code is a CRC-8 computed over the four header bytes; the byte after them must equal that CRC. While a tributary is locked, each cell with a correct header is passed downstream as 53 consecutive tagged output bytes, and its first byte is marked. Idle cells and cells with a wrong header are dropped, and no attempt is made to repair them. A per-tributary status bit shows which tributaries are locked. The output trails the input by four bytes of the same tributary plus one register stage, because the header can only be judged once its check byte has arrived.

Top module: `cell_delin`

## Requirements
- R1: While searching, a tributary tests every byte position. The four previous bytes of that tributary are taken as a header and the current byte as its check byte. The first match moves the tributary to confirming, and from then on headers are tested every 53 bytes of that tributary.
- R2: A header is correct when its check byte equals the CRC-8 of the four header bytes, taken most significant bit first, with generator x^8+x^2+x+1 and zero initial value, XORed with 0x55.
- R3: A tributary becomes locked, and its `sync_stat` bit rises, on its SYNC_CNT-th consecutive correct header (default 6). The match found while searching counts as the first.
- R4: A wrong header while confirming sends the tributary back to searching. The count of correct headers then starts again from zero.
- R5: A locked tributary goes back to searching after LOSS_CNT consecutive wrong headers (default 7). One correct header in between resets that count.
- R6: While locked, each cell with a correct header that is not idle is output as 53 bytes in arrival order. `out_sop` is set on the first header byte, and `out_trib` carries the tributary tag. The cell that completes the lock is not output.
- R7: A cell whose header bytes are 00 00 00 01 is idle and is never output, even when its check byte is correct.
- R8: A cell whose check byte is off by even a single bit is dropped, not corrected.
- R9: Tributaries are handled independently. Interleaving them with different starting offsets does not change when each one locks or which cells each one forwards.
- R10: `out_valid` is set only in the cycle after an accepted input byte that belongs to a forwarded cell. Reset clears every `sync_stat` bit and `out_valid`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | An input byte is present this cycle |
| in_byte | input | 8 | Received payload byte |
| in_trib | input | TAG_W | Tributary tag of the input byte |
| out_valid | output | 1 | A delineated cell byte is present |
| out_byte | output | 8 | Delineated cell byte |
| out_sop | output | 1 | First byte of a cell |
| out_trib | output | TAG_W | Tributary tag of the output byte |
| sync_stat | output | NUM_TRIB | Per-tributary locked flag |

## Verification
The hardest condition to reach from the ports is four tributaries interleaved byte by byte, each at a different boundary offset, each locking at a different moment. At the same time none of them may find a false match in the others' data. The stimulus starts each tributary's cells after a different run of zero bytes. Zero bytes can never form a correct header, so only the planted headers can lock. A second hard point is a single correct header inside a run of wrong ones. It is reached by placing one good cell between the wrong cells of a locked stream. The bench then checks that lock survives six more wrong cells and is lost on the seventh.

// File: rtl/cd_pkg.sv
package cd_pkg;

    localparam int CELL_LEN  = 53;
    localparam int HDR_LEN   = 4;
    localparam int HEC_POS   = HDR_LEN;
    localparam logic [7:0]  HEC_COSET = 8'h55;
    localparam logic [7:0]  HEC_POLY  = 8'h07;
    localparam logic [31:0] IDLE_HDR  = 32'h0000_0001;

    typedef enum logic [1:0] {
        ST_HUNT = 2'd0,
        ST_PRE  = 2'd1,
        ST_SYNC = 2'd2
    } dl_state_e;

    typedef struct packed {
        logic       vld;
        logic       sop;
        logic [7:0] data;
    } fwd_beat_t;

    function automatic logic [7:0] hec_calc(input logic [31:0] hdr);
        logic [7:0] crc;
        logic       fb;
        crc = 8'h00;
        for (int i = 31; i >= 0; i--) begin
            fb  = crc[7] ^ hdr[i];
            crc = {crc[6:0], 1'b0} ^ (fb ? HEC_POLY : 8'h00);
        end
        return crc ^ HEC_COSET;
    endfunction

endpackage

// File: rtl/cd_hec_check.sv
module cd_hec_check
    import cd_pkg::*;
(
    input  logic [31:0] hdr,
    input  logic [7:0]  hec_byte,
    output logic        match,
    output logic        idle
);
    always_comb begin
        match = (hec_calc(hdr) == hec_byte);
        idle  = match && (hdr == IDLE_HDR);
    end
endmodule

// File: rtl/cd_lane.sv
module cd_lane
    import cd_pkg::*;
#(
    parameter int SYNC_CNT = 6,
    parameter int LOSS_CNT = 7,
    localparam int CNT_MAX = (SYNC_CNT > LOSS_CNT) ? SYNC_CNT : LOSS_CNT,
    localparam int CNT_W   = $clog2(CNT_MAX + 1),
    localparam int POS_W   = $clog2(CELL_LEN)
)(
    input  logic       clk,
    input  logic       rst,
    input  logic       en,
    input  logic [7:0] byte_in,
    output fwd_beat_t  beat,
    output logic       locked
);
    logic [HDR_LEN-1:0][7:0] hist;
    logic [POS_W-1:0]        pos, pos_n;
    logic [CNT_W-1:0]        cnt, cnt_n;
    dl_state_e               state, state_n;
    logic                    fwd_q, fwd_n;
    logic                    take;
    logic                    match, idle;
    logic                    at_hec;

    cd_hec_check u_hec (
        .hdr      ({hist[3], hist[2], hist[1], hist[0]}),
        .hec_byte (byte_in),
        .match    (match),
        .idle     (idle)
    );

    assign at_hec = (state != ST_HUNT) && (pos == POS_W'(HEC_POS));

    always_comb begin
        state_n = state;
        cnt_n   = cnt;
        fwd_n   = fwd_q;
        take    = 1'b0;
        pos_n   = (pos == POS_W'(CELL_LEN - 1)) ? '0 : pos + 1'b1;
        case (state)
            ST_HUNT: begin
                fwd_n = 1'b0;
                if (match) begin
                    pos_n = POS_W'(HEC_POS + 1);
                    if (SYNC_CNT <= 1) begin
                        state_n = ST_SYNC;
                        cnt_n   = '0;
                    end else begin
                        state_n = ST_PRE;
                        cnt_n   = CNT_W'(1);
                    end
                end
            end
            ST_PRE: begin
                if (at_hec) begin
                    if (match) begin
                        if (int'(cnt) + 1 >= SYNC_CNT) begin
                            state_n = ST_SYNC;
                            cnt_n   = '0;
                        end else begin
                            cnt_n = CNT_W'(int'(cnt) + 1);
                        end
                    end else begin
                        state_n = ST_HUNT;
                        cnt_n   = '0;
                    end
                    fwd_n = 1'b0;
                end
            end
            ST_SYNC: begin
                if (at_hec) begin
                    if (match) begin
                        cnt_n = '0;
                        take  = !idle;
                    end else if (int'(cnt) + 1 >= LOSS_CNT) begin
                        state_n = ST_HUNT;
                        cnt_n   = '0;
                    end else begin
                        cnt_n = CNT_W'(int'(cnt) + 1);
                    end
                    fwd_n = take;
                end
            end
            default: begin
                state_n = ST_HUNT;
                cnt_n   = '0;
                fwd_n   = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hist  <= '0;
            pos   <= '0;
            cnt   <= '0;
            state <= ST_HUNT;
            fwd_q <= 1'b0;
        end else if (en) begin
            hist  <= {hist[2:0], byte_in};
            pos   <= pos_n;
            cnt   <= cnt_n;
            state <= state_n;
            fwd_q <= fwd_n;
        end
    end

    always_comb begin
        beat.data = hist[3];
        beat.sop  = en && at_hec && take;
        beat.vld  = en && (at_hec ? take : fwd_q);
    end

    assign locked = (state == ST_SYNC);

endmodule

// File: rtl/cell_delin.sv
module cell_delin
    import cd_pkg::*;
#(
    parameter int NUM_TRIB = 4,
    parameter int SYNC_CNT = 6,
    parameter int LOSS_CNT = 7,
    localparam int TAG_W   = (NUM_TRIB > 1) ? $clog2(NUM_TRIB) : 1
)(
    input  logic                clk,
    input  logic                rst,
    input  logic                in_valid,
    input  logic [7:0]          in_byte,
    input  logic [TAG_W-1:0]    in_trib,
    output logic                out_valid,
    output logic [7:0]          out_byte,
    output logic                out_sop,
    output logic [TAG_W-1:0]    out_trib,
    output logic [NUM_TRIB-1:0] sync_stat
);
    fwd_beat_t beats [NUM_TRIB];
    fwd_beat_t sel;

    for (genvar g = 0; g < NUM_TRIB; g++) begin : g_lane
        logic lane_en;
        assign lane_en = in_valid && (in_trib == TAG_W'(g));
        cd_lane #(
            .SYNC_CNT (SYNC_CNT),
            .LOSS_CNT (LOSS_CNT)
        ) u_lane (
            .clk     (clk),
            .rst     (rst),
            .en      (lane_en),
            .byte_in (in_byte),
            .beat    (beats[g]),
            .locked  (sync_stat[g])
        );
    end

    always_comb begin
        sel = '0;
        for (int i = 0; i < NUM_TRIB; i++) begin
            if (in_trib == TAG_W'(i)) sel = beats[i];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_sop   <= 1'b0;
            out_byte  <= '0;
            out_trib  <= '0;
        end else begin
            out_valid <= in_valid && sel.vld;
            out_sop   <= in_valid && sel.sop;
            out_byte  <= sel.data;
            out_trib  <= in_trib;
        end
    end

endmodule

// File: rtl/cell_delin_chk.sv
module cell_delin_chk #(
    parameter int NUM_TRIB = 4,
    parameter int TAG_W    = 2
)(
    input logic                clk,
    input logic                rst,
    input logic                in_valid,
    input logic [TAG_W-1:0]    in_trib,
    input logic                out_valid,
    input logic                out_sop,
    input logic [TAG_W-1:0]    out_trib,
    input logic [NUM_TRIB-1:0] sync_stat
);
    a_r6_sop_has_valid: assert property (@(posedge clk) disable iff (rst)
        out_sop |-> out_valid);

    a_r10_out_follows_in: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $past(in_valid));

    a_r6_tag_follows_in: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (out_trib == $past(in_trib)));

    a_r6_out_only_locked: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> sync_stat[out_trib]);

    a_r9_one_lane_moves: assert property (@(posedge clk) disable iff (rst)
        $countones(sync_stat ^ $past(sync_stat)) <= 1);

    for (genvar g = 0; g < NUM_TRIB; g++) begin : g_lane_chk
        a_r3_lock_on_own_byte: assert property (@(posedge clk) disable iff (rst)
            $rose(sync_stat[g]) |-> $past(in_valid && (in_trib == TAG_W'(g))));
        a_r5_loss_on_own_byte: assert property (@(posedge clk) disable iff (rst)
            $fell(sync_stat[g]) |-> $past(in_valid && (in_trib == TAG_W'(g))));
    end
endmodule

bind cell_delin cell_delin_chk #(
    .NUM_TRIB (NUM_TRIB),
    .TAG_W    (TAG_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_trib   (in_trib),
    .out_valid (out_valid),
    .out_sop   (out_sop),
    .out_trib  (out_trib),
    .sync_stat (sync_stat)
);

// File: tb/cell_delin_tb.sv
module cell_delin_tb_top;
    localparam int NT = 4;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       in_valid = 1'b0;
    logic [7:0] in_byte = 8'h00;
    logic [1:0] in_trib = 2'd0;
    logic       out_valid, out_sop;
    logic [7:0] out_byte;
    logic [1:0] out_trib;
    logic [NT-1:0] sync_stat;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    int sops   [NT];
    int vbytes [NT];
    int oidx   [NT];
    logic [7:0] exp_h3 [NT];

    // cell kind in [3:2]: 0 good, 1 bad check byte, 2 idle; [1] lock after cell; [0] cell forwarded
    localparam logic [3:0] SEQ [0:16] = '{
        4'b0000, 4'b0000, 4'b0000, 4'b0000, 4'b0000,
        4'b0010, 4'b0011, 4'b1010, 4'b0110, 4'b0011,
        4'b0110, 4'b0110, 4'b0110, 4'b0110, 4'b0110,
        4'b0110, 4'b0100
    };

    always #10 clk = ~clk;

    cell_delin #(.NUM_TRIB(NT), .SYNC_CNT(6), .LOSS_CNT(7)) dut_i (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_byte(in_byte),
        .in_trib(in_trib), .out_valid(out_valid), .out_byte(out_byte),
        .out_sop(out_sop), .out_trib(out_trib), .sync_stat(sync_stat)
    );

    function automatic logic [7:0] ref_hec(input logic [31:0] h);
        logic [39:0] m;
        m = {h, 8'h00};
        for (int i = 39; i >= 8; i--) begin
            if (m[i]) m[i -: 9] = m[i -: 9] ^ 9'h107;
        end
        return m[7:0] ^ 8'h55;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic send_byte(input int t, input logic [7:0] b);
        @(negedge clk);
        in_valid = 1'b1;
        in_trib  = 2'(t);
        in_byte  = b;
    endtask

    task automatic go_idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
        end
    endtask

    task automatic send_cell(input int t, input int kind, input logic [7:0] h3);
        logic [31:0] hdr;
        logic [7:0]  hec;
        hdr = (kind == 2) ? 32'h0000_0001 : {24'h0, h3};
        hec = ref_hec(hdr) ^ ((kind == 1) ? 8'h01 : 8'h00);
        for (int k = 0; k < 53; k++) begin
            if (k < 4)       send_byte(t, hdr[31 - 8*k -: 8]);
            else if (k == 4) send_byte(t, hec);
            else             send_byte(t, 8'h00);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        in_valid = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        for (int t = 0; t < NT; t++) begin
            sops[t] = 0; vbytes[t] = 0; oidx[t] = 0;
        end
    endtask

    function automatic logic [7:0] stream_byte(input int t, input int step, input int off);
        int idx, k;
        idx = step - off;
        if (idx < 0 || idx >= 8*53) return 8'h00;
        k = idx % 53;
        if (k < 3)  return 8'h00;
        if (k == 3) return exp_h3[t];
        if (k == 4) return ref_hec({24'h0, exp_h3[t]});
        return 8'h00;
    endfunction

    // output monitor, sampled on the falling edge
    always @(negedge clk) begin
        if (!rst && out_valid) begin
            vbytes[out_trib]++;
            if (out_sop) begin
                sops[out_trib]++;
                oidx[out_trib] = 0;
                check(out_byte == 8'h00, "R6 first header byte", out_byte, 0);
            end else begin
                oidx[out_trib]++;
            end
            if (oidx[out_trib] == 3)
                check(out_byte == exp_h3[out_trib], "R6 header byte 3", out_byte, exp_h3[out_trib]);
            if (oidx[out_trib] == 4)
                check(out_byte == ref_hec({24'h0, exp_h3[out_trib]}), "R2 check byte in output",
                      out_byte, ref_hec({24'h0, exp_h3[out_trib]}));
        end
    end

    initial begin
        for (int c = 0; c < 150000; c++) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int exp_sops;
        exp_h3[0] = 8'h20; exp_h3[1] = 8'h30; exp_h3[2] = 8'h40; exp_h3[3] = 8'h50;
        do_reset();
        @(negedge clk);
        check(sync_stat == '0, "R10 reset sync", sync_stat, 0);
        check(out_valid == 1'b0, "R10 reset out_valid", out_valid, 0);

        // table walk on tributary 0, unaligned start (R1, R3, R5, R6, R7, R8)
        for (int i = 0; i < 9; i++) send_byte(0, 8'h00);
        exp_sops = 0;
        for (int i = 0; i < 17; i++) begin
            send_cell(0, int'(SEQ[i][3:2]), exp_h3[0]);
            go_idle(1);
            exp_sops += int'(SEQ[i][0]);
            check(sync_stat[0] == SEQ[i][1], $sformatf("R3/R5 lock after cell %0d", i),
                  sync_stat[0], SEQ[i][1]);
            check(sops[0] == exp_sops, $sformatf("R6/R7/R8 forwarded after cell %0d", i),
                  sops[0], exp_sops);
        end
        check(vbytes[0] == 106, "R6 forwarded byte count", vbytes[0], 106);

        // reset clears a stream (R10)
        do_reset();
        @(negedge clk);
        check(sync_stat == '0, "R10 reset after run", sync_stat, 0);

        // confirming stage aborted by a wrong header (R4)
        for (int i = 0; i < 3; i++) send_byte(1, 8'h00);
        for (int i = 0; i < 3; i++) send_cell(1, 0, exp_h3[1]);
        send_cell(1, 1, exp_h3[1]);
        for (int i = 0; i < 5; i++) send_cell(1, 0, exp_h3[1]);
        go_idle(1);
        check(sync_stat[1] == 1'b0, "R4 count restarted", sync_stat[1], 0);
        send_cell(1, 0, exp_h3[1]);
        go_idle(1);
        check(sync_stat[1] == 1'b1, "R4 lock after restart", sync_stat[1], 1);
        check(sops[1] == 0, "R6 lock cell not forwarded", sops[1], 0);

        // four interleaved, unaligned tributaries (R9, R1)
        do_reset();
        for (int step = 0; step < 40 + 8*53 + 8; step++) begin
            for (int t = 0; t < NT; t++) begin
                int off;
                off = (t == 0) ? 0 : (t == 1) ? 13 : (t == 2) ? 27 : 40;
                send_byte(t, stream_byte(t, step, off));
            end
        end
        go_idle(2);
        for (int t = 0; t < NT; t++) begin
            check(sync_stat[t] == 1'b1, $sformatf("R9 lane %0d locked", t), sync_stat[t], 1);
            check(sops[t] == 2, $sformatf("R9 lane %0d cells", t), sops[t], 2);
            check(vbytes[t] == 106, $sformatf("R9 lane %0d bytes", t), vbytes[t], 106);
        end

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule